// File: doc/BRIEF.md
# Command Frame CRC Checker

This block guards the command path of a peripheral that a host drives over a byte-oriented serial link. A serial shifter, outside the block, hands over each received byte as a one-cycle valid strobe. The block also presents the byte that the shifter must send during the next exchange. A protected command frame has four bytes: two command bytes, the host's 8-bit CRC over those two bytes, and a zero filler byte. The block computes its own CRC while the bytes arrive. During bytes 2 and 3 it echoes bytes 1 and 2 back to the host. During byte 4 it answers with its own CRC when the two agree, or with the bitwise inverse of that CRC when they do not.

A frame that passes gives a one-cycle command-valid strobe that carries both command bytes. Downstream decode answers in that same cycle with the length of any read payload. The block then passes payload bytes from an input port to the host, one per exchange, and appends a CRC over them. A failed frame is dropped, sets a sticky error flag, and leaves the block ready for the next frame. A global enable turns off all checking and all CRC bytes, which shortens a command frame to two bytes. A frame-abort input (chip-select release) returns the block to the start of a frame at any point.

Top module: `cmdcrc_checker`

## Requirements
- R1: Every CRC is 8 bits with generator x^8+x^2+x+1 (low byte 0x07), preset to 0xFF before the first byte of each protected run, and processed most significant bit first with no final inversion.
- R2: With the CRC enabled, `txByte` is 0x00 during byte 1 of a frame, equals received byte 1 during byte 2, and equals received byte 2 during byte 3.
- R3: When received byte 3 equals the CRC over bytes 1 and 2, `txByte` during byte 4 is that CRC. `cmdValid` is high for exactly one clock, starting on the clock after byte 4 is accepted, with `cmdFirst` and `cmdSecond` holding bytes 1 and 2.
- R4: When received byte 3 differs from the computed CRC, `txByte` during byte 4 is the bitwise inverse of the computed CRC, and `cmdValid` stays low for that frame.
- R5: A CRC mismatch sets `crcErr`, which stays set through later good frames until `errClear` is pulsed. A set in the same cycle as a clear wins.
- R6: After byte 4 of a failed frame, the next byte is taken as byte 1 of a new frame, and that frame is processed normally.
- R7: `payloadLen` (0 to 4) is sampled while `cmdValid` is high. For a nonzero length, `txByte` follows `payloadData` for that many exchanges, with `payloadIdx` counting 0, 1, and so on. The next exchange carries the R1 CRC over those payload bytes. The exchange after that is byte 1 of a new frame.
- R8: With `crcEnable` low, a command frame is two bytes, `cmdValid` follows byte 2, no mismatch can occur, and any payload is followed directly by a new frame with no CRC byte.
- R9: A `frameAbort` pulse discards a partial frame: `txByte` returns to 0x00, and the next byte is taken as byte 1.
- R10: After reset, `txByte` is 0x00, `cmdValid` and `crcErr` are low, and `payloadIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| crcEnable | input | 1 | Enables CRC check and CRC bytes |
| frameAbort | input | 1 | Restart frame (chip-select release) |
| rxValid | input | 1 | One-cycle strobe: a byte was received |
| rxByte | input | 8 | Received byte |
| payloadLen | input | 3 | Read payload length, sampled during cmdValid |
| payloadData | input | 8 | Payload byte selected by payloadIdx |
| errClear | input | 1 | Clears the sticky error flag |
| txByte | output | 8 | Byte to send during the next exchange |
| payloadIdx | output | 3 | Index of the payload byte being sent |
| cmdValid | output | 1 | One-cycle accepted-command strobe |
| cmdFirst | output | 8 | Command byte 1 |
| cmdSecond | output | 8 | Command byte 2 |
| crcErr | output | 1 | Sticky CRC mismatch flag |

## Verification
Command pairs of all zeros, all ones and mixed bits are sent with correct CRCs, so a wrong polynomial, preset or bit order shows up as a wrong byte-4 answer. The same pairs with a corrupted CRC byte separate the inverted answer from the plain one, and show whether the error flag stays set or clears. Reads of one, three and four bytes check the payload pass-through and the trailing CRC, as well as the return to byte 1 afterwards. Frames with the CRC disabled, and an abort in the middle of a frame, show whether the block counts bytes correctly.

// File: rtl/cmdcrc_pkg.sv
package cmdcrc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capFirst;
    logic capSecond;
    logic checkCrc;
    logic clearTx;
    logic startPay;
    logic foldPay;
    logic loadPayCrc;
  } strobe_t;

  // One byte through the CRC register, MSB first
  function automatic byte_t crcStep(byte_t seed, byte_t data, byte_t poly);
    byte_t c;
    logic fb;
    c = seed;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[BYTE_W-1] ^ data[i];
      c = {c[BYTE_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/cmdcrc_ctrl.sv
module cmdcrc_ctrl
  import cmdcrc_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             crcEnable,
  input  logic             frameAbort,
  input  logic             rxValid,
  input  logic             crcMatch,
  input  logic             payLast,
  input  logic [LEN_W-1:0] payloadLen,
  input  logic             errClear,
  output strobe_t          strobe,
  output logic             payPhase,
  output logic             cmdValid,
  output logic             crcErr
);
  typedef enum logic [2:0] {
    ST_B1, ST_B2, ST_B3, ST_B4, ST_DECIDE, ST_PAY, ST_RCRC
  } state_t;

  state_t state, stateNext;
  logic   matchReg;
  logic   errSet;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    errSet    = 1'b0;
    unique case (state)
      ST_B1: if (rxValid) begin
        strobe.capFirst = 1'b1;
        stateNext = ST_B2;
      end
      ST_B2: if (rxValid) begin
        strobe.capSecond = 1'b1;
        stateNext = crcEnable ? ST_B3 : ST_DECIDE;
      end
      ST_B3: if (rxValid) begin
        strobe.checkCrc = 1'b1;
        stateNext = ST_B4;
      end
      ST_B4: if (rxValid) begin
        strobe.clearTx = 1'b1;
        if (matchReg) stateNext = ST_DECIDE;
        else begin
          errSet    = 1'b1;
          stateNext = ST_B1;
        end
      end
      ST_DECIDE: begin
        strobe.clearTx = 1'b1;
        if (payloadLen != '0) begin
          strobe.startPay = 1'b1;
          stateNext = ST_PAY;
        end else stateNext = ST_B1;
      end
      ST_PAY: if (rxValid) begin
        strobe.foldPay = 1'b1;
        if (payLast) begin
          if (crcEnable) begin
            strobe.loadPayCrc = 1'b1;
            stateNext = ST_RCRC;
          end else begin
            strobe.clearTx = 1'b1;
            stateNext = ST_B1;
          end
        end
      end
      ST_RCRC: if (rxValid) begin
        strobe.clearTx = 1'b1;
        stateNext = ST_B1;
      end
      default: stateNext = ST_B1;
    endcase
    if (frameAbort) begin
      strobe    = '0;
      errSet    = 1'b0;
      stateNext = ST_B1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_B1;
      matchReg <= 1'b0;
      crcErr   <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.checkCrc) matchReg <= crcMatch;
      if (errSet) crcErr <= 1'b1;
      else if (errClear) crcErr <= 1'b0;
    end
  end

  assign cmdValid = (state == ST_DECIDE);
  assign payPhase = (state == ST_PAY);

  // R3: the accepted-command strobe lasts one clock
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R4: a mismatched frame never yields a command
  assert_no_valid_on_mismatch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_B4 && rxValid && !matchReg && !frameAbort) |=> (!cmdValid && crcErr));

  // R5: the error flag holds until cleared
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !errClear) |=> crcErr);

  // R9: abort returns to the start of a frame
  assert_abort_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameAbort |=> (state == ST_B1 && !cmdValid && !payPhase));
endmodule

// File: rtl/cmdcrc_datapath.sv
module cmdcrc_datapath
  import cmdcrc_pkg::*;
#(
  parameter int    LEN_W    = 3,
  parameter byte_t CRC_POLY = 8'h07,
  parameter byte_t CRC_INIT = 8'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             payPhase,
  input  logic             frameAbort,
  input  byte_t            rxByte,
  input  logic [LEN_W-1:0] payloadLen,
  input  byte_t            payloadData,
  output logic             crcMatch,
  output logic             payLast,
  output byte_t            txByte,
  output logic [LEN_W-1:0] payloadIdx,
  output byte_t            cmdFirst,
  output byte_t            cmdSecond
);
  byte_t            cmdCrc, respCrc, txReg;
  logic [LEN_W-1:0] payLen;

  assign crcMatch = (rxByte == cmdCrc);
  assign payLast  = (payloadIdx == payLen - LEN_W'(1));
  assign txByte   = payPhase ? payloadData : txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdFirst   <= '0;
      cmdSecond  <= '0;
      cmdCrc     <= CRC_INIT;
      respCrc    <= CRC_INIT;
      txReg      <= '0;
      payloadIdx <= '0;
      payLen     <= '0;
    end else if (frameAbort) begin
      cmdCrc     <= CRC_INIT;
      txReg      <= '0;
      payloadIdx <= '0;
    end else begin
      if (strobe.capFirst) begin
        cmdFirst <= rxByte;
        cmdCrc   <= crcStep(CRC_INIT, rxByte, CRC_POLY);
        txReg    <= rxByte;
      end
      if (strobe.capSecond) begin
        cmdSecond <= rxByte;
        cmdCrc    <= crcStep(cmdCrc, rxByte, CRC_POLY);
        txReg     <= rxByte;
      end
      if (strobe.checkCrc) txReg <= crcMatch ? cmdCrc : ~cmdCrc;
      if (strobe.clearTx) txReg <= '0;
      if (strobe.startPay) begin
        payloadIdx <= '0;
        payLen     <= payloadLen;
        respCrc    <= CRC_INIT;
      end
      if (strobe.foldPay) begin
        respCrc    <= crcStep(respCrc, payloadData, CRC_POLY);
        payloadIdx <= payloadIdx + LEN_W'(1);
      end
      if (strobe.loadPayCrc) txReg <= crcStep(respCrc, payloadData, CRC_POLY);
    end
  end

  // R7: a payload run starts at index zero
  assert_pay_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.startPay && !frameAbort) |=> (payloadIdx == '0));

  // R9: abort clears the outgoing byte
  assert_abort_tx_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameAbort |=> (txReg == '0));
endmodule

// File: rtl/cmdcrc_checker.sv
module cmdcrc_checker
  import cmdcrc_pkg::*;
#(
  parameter int          MAX_PAYLOAD = 4,
  parameter logic [7:0]  CRC_POLY    = 8'h07,
  parameter logic [7:0]  CRC_INIT    = 8'hFF,
  localparam int         LEN_W       = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             crcEnable,
  input  logic             frameAbort,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic [LEN_W-1:0] payloadLen,
  input  logic [7:0]       payloadData,
  input  logic             errClear,
  output logic [7:0]       txByte,
  output logic [LEN_W-1:0] payloadIdx,
  output logic             cmdValid,
  output logic [7:0]       cmdFirst,
  output logic [7:0]       cmdSecond,
  output logic             crcErr
);
  strobe_t strobe;
  logic    payPhase, crcMatch, payLast;

  cmdcrc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .crcEnable(crcEnable), .frameAbort(frameAbort),
    .rxValid(rxValid), .crcMatch(crcMatch), .payLast(payLast),
    .payloadLen(payloadLen), .errClear(errClear), .strobe(strobe),
    .payPhase(payPhase), .cmdValid(cmdValid), .crcErr(crcErr)
  );

  cmdcrc_datapath #(.LEN_W(LEN_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .payPhase(payPhase),
    .frameAbort(frameAbort), .rxByte(rxByte), .payloadLen(payloadLen),
    .payloadData(payloadData), .crcMatch(crcMatch), .payLast(payLast),
    .txByte(txByte), .payloadIdx(payloadIdx), .cmdFirst(cmdFirst),
    .cmdSecond(cmdSecond)
  );
endmodule

// File: tb/cmdcrc_checker_bench.sv
module cmdcrc_checker_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       crcEnable = 1'b1;
  logic       frameAbort = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic [2:0] payloadLen = '0;
  logic [7:0] payloadData;
  logic       errClear = 1'b0;
  logic [7:0] txByte, cmdFirst, cmdSecond;
  logic [2:0] payloadIdx;
  logic       cmdValid, crcErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] payMem [4];

  always #5 clk = ~clk;
  assign payloadData = payMem[payloadIdx[1:0]];

  cmdcrc_checker u_cmdcrc_checker (
    .clk(clk), .rstN(rstN), .crcEnable(crcEnable), .frameAbort(frameAbort),
    .rxValid(rxValid), .rxByte(rxByte), .payloadLen(payloadLen),
    .payloadData(payloadData), .errClear(errClear), .txByte(txByte),
    .payloadIdx(payloadIdx), .cmdValid(cmdValid), .cmdFirst(cmdFirst),
    .cmdSecond(cmdSecond), .crcErr(crcErr)
  );

  function automatic logic [7:0] refCrc(logic [7:0] seed, logic [7:0] d);
    logic [7:0] c;
    c = seed ^ d;
    repeat (8) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One byte exchange: returns byte sent during it and the strobe seen after
  task automatic xfer(logic [7:0] b, output logic [7:0] sent, output logic v,
                      output logic late);
    sent = txByte;
    rxByte = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    v = cmdValid;
    @(negedge clk);
    late = cmdValid;
  endtask

  task automatic runFrame(string tag, logic [7:0] a, logic [7:0] b, bit corrupt,
                          int len, bit en);
    logic [7:0] sent, expCrc, payCrc;
    logic v, late;
    crcEnable = en;
    payloadLen = 3'(len);
    expCrc = refCrc(refCrc(8'hFF, a), b);
    xfer(a, sent, v, late);
    chk({tag, " R2 idle byte"}, {8'h0, sent}, 16'h0);
    xfer(b, sent, v, late);
    chk({tag, " R2 echo first"}, {8'h0, sent}, {8'h0, a});
    if (en) begin
      xfer(corrupt ? (expCrc ^ 8'h5A) : expCrc, sent, v, late);
      chk({tag, " R2 echo second"}, {8'h0, sent}, {8'h0, b});
      xfer(8'h00, sent, v, late);
      if (corrupt) begin
        chk({tag, " R4 inverted crc"}, {8'h0, sent}, {8'h0, ~expCrc});
        chk({tag, " R4 no valid"}, {15'h0, v}, 16'h0);
      end else begin
        chk({tag, " R1 R3 crc answer"}, {8'h0, sent}, {8'h0, expCrc});
        chk({tag, " R3 valid"}, {15'h0, v}, 16'h1);
        chk({tag, " R3 pulse"}, {15'h0, late}, 16'h0);
      end
    end else begin
      chk({tag, " R8 valid after two"}, {15'h0, v}, 16'h1);
    end
    if (!en || !corrupt) chk({tag, " R3 bytes"}, {cmdFirst, cmdSecond}, {a, b});
    if (!corrupt && len > 0) begin
      payCrc = 8'hFF;
      for (int i = 0; i < len; i++) begin
        chk({tag, " R7 idx"}, {13'h0, payloadIdx}, 16'(i));
        xfer(8'h00, sent, v, late);
        chk({tag, " R7 payload"}, {8'h0, sent}, {8'h0, payMem[i]});
        payCrc = refCrc(payCrc, payMem[i]);
      end
      if (en) begin
        xfer(8'h00, sent, v, late);
        chk({tag, " R7 payload crc"}, {8'h0, sent}, {8'h0, payCrc});
      end
    end
  endtask

  task automatic testReset();
    chk("R10 tx", {8'h0, txByte}, 16'h0);
    chk("R10 valid/err", {14'h0, cmdValid, crcErr}, 16'h0);
    chk("R10 idx", {13'h0, payloadIdx}, 16'h0);
  endtask

  task automatic testGoodWrites();
    runFrame("zeros", 8'h00, 8'h00, 0, 0, 1);
    runFrame("ones", 8'hFF, 8'hFF, 0, 0, 1);
    runFrame("mixed", 8'h42, 8'h13, 0, 0, 1);
    chk("R5 no err on good", {15'h0, crcErr}, 16'h0);
  endtask

  task automatic testBadCrc();
    runFrame("bad", 8'hA5, 8'h3C, 1, 0, 1);
    chk("R5 err set", {15'h0, crcErr}, 16'h1);
    runFrame("after bad", 8'h10, 8'h20, 0, 0, 1);
    chk("R6 R5 err sticky", {15'h0, crcErr}, 16'h1);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk("R5 err cleared", {15'h0, crcErr}, 16'h0);
  endtask

  task automatic testReads();
    payMem[0] = 8'h11; payMem[1] = 8'h22; payMem[2] = 8'h33; payMem[3] = 8'hC4;
    runFrame("read1", 8'h21, 8'h00, 0, 1, 1);
    runFrame("read3", 8'h12, 8'h00, 0, 3, 1);
    runFrame("read4", 8'h13, 8'hFF, 0, 4, 1);
    runFrame("after read", 8'h05, 8'h06, 0, 0, 1);
  endtask

  task automatic testDisabled();
    runFrame("off write", 8'h77, 8'h88, 0, 0, 0);
    runFrame("off read", 8'h12, 8'h00, 0, 3, 0);
    runFrame("off next", 8'h01, 8'h02, 0, 0, 0);
    chk("R8 no err", {15'h0, crcErr}, 16'h0);
  endtask

  task automatic testAbort();
    logic [7:0] sent;
    logic v, late;
    crcEnable = 1'b1;
    payloadLen = '0;
    xfer(8'h9A, sent, v, late);
    xfer(8'hBC, sent, v, late);
    frameAbort = 1'b1;
    @(negedge clk);
    frameAbort = 1'b0;
    chk("R9 tx cleared", {8'h0, txByte}, 16'h0);
    runFrame("post abort R9", 8'h31, 8'h32, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGoodWrites();
    testBadCrc();
    testReads();
    testDisabled();
    testAbort();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule